// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Compare Flags

This block is the combinational integer execution unit of a small RISC datapath. Two operand words and a 4-bit operation code go in. A result word, a zero flag and a signed-overflow flag come out in the same cycle. Addition and subtraction share a single ripple carry chain: subtraction inverts the second operand and feeds a carry of one into the low bit. The set-on-less-than operation and the equality test used by branches both reuse that subtraction.

The bitwise functions (AND, OR, NOR, XOR) come from one gate per function. An output multiplexer chooses which function drives the result. Shifts, multiplication, division and immediate sign extension live elsewhere in the datapath. The word width is a parameter and defaults to 32.

Top module: `int_alu`

## Requirements
- R1: Code 2 (4'b0010) returns the sum of the two operands modulo 2^WIDTH.
- R2: Code 6 (4'b0110) returns operand A minus operand B modulo 2^WIDTH.
- R3: For codes 2 and 6 the overflow flag is 1 exactly when the two's-complement result differs from the true signed sum or difference. For add, this happens when the operands share a sign and the result sign differs from it. For subtract, it happens when the operands differ in sign and the result sign differs from A.
- R4: For every code other than 2 and 6, the overflow flag is 0.
- R5: Code 0 returns A AND B, code 1 returns A OR B, code 12 returns NOT(A OR B), and code 13 returns A XOR B, all bit by bit.
- R6: Code 7 returns 1 in bit 0 when A is less than B as signed numbers, including when A minus B overflows, and returns 0 in bit 0 otherwise. Bits WIDTH-1 down to 1 are always 0.
- R7: The zero flag is 1 exactly when every result bit is 0, for every code. After code 6 it therefore signals A equal to B.
- R8: Any code not listed above returns an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | WIDTH | First operand (minuend for subtract and compare) |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected function output |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the unit. One uses the default WIDTH of 32 and is driven with the signed extremes, their neighbours, alternating bit patterns and random words under every one of the 16 codes. The second copy uses WIDTH of 4, which makes it practical to drive every operand pair under every code. At that width, each overflow case, each wrapping compare and each equality case is covered exhaustively, not just sampled.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd6,
        OP_SLT = 4'd7,
        OP_NOR = 4'd12,
        OP_XOR = 4'd13
    } alu_op_e;

    function automatic logic op_is_arith(input logic [3:0] code);
        return (code == OP_ADD) || (code == OP_SUB);
    endfunction

    function automatic logic op_uses_sub(input logic [3:0] code);
        return (code == OP_SUB) || (code == OP_SLT);
    endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf_raw
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    assign carry[0] = do_sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_eff[i]     = in_b[i] ^ do_sub;
        assign sum[i]       = in_a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1]   = (in_a[i] & b_eff[i]) |
                              (in_a[i] & carry[i]) |
                              (b_eff[i] & carry[i]);
    end

    assign ovf_raw = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o,
    output logic [WIDTH-1:0] xor_o
);

    assign and_o = in_a & in_b;
    assign or_o  = in_a | in_b;
    assign nor_o = ~(in_a | in_b);
    assign xor_o = in_a ^ in_b;

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_w;
    logic             ovf_w;
    logic [WIDTH-1:0] and_w, or_w, nor_w, xor_w;
    logic             less_w;
    alu_op_e          op_e;

    assign op_e = alu_op_e'(op_sel);

    int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .in_a    (opnd_a),
        .in_b    (opnd_b),
        .do_sub  (op_uses_sub(op_sel)),
        .sum     (sum_w),
        .ovf_raw (ovf_w)
    );

    int_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .in_a  (opnd_a),
        .in_b  (opnd_b),
        .and_o (and_w),
        .or_o  (or_w),
        .nor_o (nor_w),
        .xor_o (xor_w)
    );

    // Sign of the difference, corrected when the subtraction wrapped
    assign less_w = sum_w[MSB] ^ ovf_w;

    always_comb begin
        case (op_e)
            OP_AND:  result = and_w;
            OP_OR:   result = or_w;
            OP_ADD:  result = sum_w;
            OP_SUB:  result = sum_w;
            OP_SLT:  result = {{(WIDTH-1){1'b0}}, less_w};
            OP_NOR:  result = nor_w;
            OP_XOR:  result = xor_w;
            default: result = '0;
        endcase
    end

    assign zero = ~|result;
    assign ovf  = op_is_arith(op_sel) & ovf_w;

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] exp_sum;
    logic [WIDTH-1:0] exp_diff;
    logic             known;

    assign exp_sum  = opnd_a + opnd_b;
    assign exp_diff = opnd_a - opnd_b;
    assign known    = op_sel inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd12, 4'd13};

    always_comb begin
        if (op_sel == 4'd2) begin
            assert_add_sum_R1: assert (result == exp_sum)
                else $error("R1 add result mismatch");
            assert_add_ovf_R3: assert (ovf == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
                else $error("R3 add overflow mismatch");
        end
        if (op_sel == 4'd6) begin
            assert_sub_diff_R2: assert (result == exp_diff)
                else $error("R2 subtract result mismatch");
            assert_sub_ovf_R3: assert (ovf == ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
                else $error("R3 subtract overflow mismatch");
        end
        if (op_sel != 4'd2 && op_sel != 4'd6) begin
            assert_no_overflow_R4: assert (!ovf)
                else $error("R4 overflow outside add/subtract");
        end
        if (op_sel == 4'd0) begin
            assert_and_R5: assert (result == (opnd_a & opnd_b)) else $error("R5 AND");
        end
        if (op_sel == 4'd13) begin
            assert_xor_R5: assert (result == (opnd_a ^ opnd_b)) else $error("R5 XOR");
        end
        if (op_sel == 4'd7) begin
            assert_slt_R6: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
                else $error("R6 set-less-than mismatch");
        end
        assert_zero_flag_R7: assert (zero == (result == '0))
            else $error("R7 zero flag mismatch");
        if (!known) begin
            assert_unknown_code_R8: assert (result == '0)
                else $error("R8 unlisted code nonzero");
        end
    end

endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH)) u_int_alu_checker (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .zero   (zero),
    .ovf    (ovf)
);

// File: tb/test_int_alu.sv
module test_int_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WIDE       = 32;
    localparam int NARROW     = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]        op_w, op_n;
    logic [WIDE-1:0]   a_w, b_w, r_w;
    logic [NARROW-1:0] a_n, b_n, r_n;
    logic              z_w, v_w, z_n, v_n;

    int total = 0;
    int bad   = 0;

    int_alu #(.WIDTH(WIDE)) i_int_alu (
        .op_sel(op_w), .opnd_a(a_w), .opnd_b(b_w),
        .result(r_w), .zero(z_w), .ovf(v_w)
    );

    int_alu #(.WIDTH(NARROW)) i_int_alu_w4 (
        .op_sel(op_n), .opnd_a(a_n), .opnd_b(b_n),
        .result(r_n), .zero(z_n), .ovf(v_n)
    );

    // Behavioural reference: integer arithmetic on sign-interpreted values
    function automatic void ref_model(input int w, input int op,
                                      input longint unsigned a, input longint unsigned b,
                                      output longint unsigned r, output bit z, output bit v);
        longint unsigned mask = (64'd1 << w) - 64'd1;
        longint sa = a[w-1] ? longint'(a) - longint'(64'd1 << w) : longint'(a);
        longint sb = b[w-1] ? longint'(b) - longint'(64'd1 << w) : longint'(b);
        longint hi = longint'(64'd1 << (w-1)) - 1;
        longint lo = -longint'(64'd1 << (w-1));
        longint full;
        v = 1'b0;
        case (op)
            0:  r = a & b;
            1:  r = a | b;
            2:  begin full = sa + sb; r = (a + b) & mask; v = (full > hi) || (full < lo); end
            6:  begin full = sa - sb; r = (a - b) & mask; v = (full > hi) || (full < lo); end
            7:  r = (sa < sb) ? 64'd1 : 64'd0;
            12: r = ~(a | b) & mask;
            13: r = a ^ b;
            default: r = 64'd0;
        endcase
        z = (r == 64'd0);
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1, 12, 13: return "R5";
            2:  return "R1";
            6:  return "R2";
            7:  return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string req, input int op, input longint unsigned a,
                           input longint unsigned b, input longint unsigned act,
                           input longint unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
        end
    endtask

    task automatic check_all(input int w, input int op, input longint unsigned a,
                             input longint unsigned b, input longint unsigned r,
                             input bit z, input bit v);
        longint unsigned er;
        bit ez, ev;
        ref_model(w, op, a, b, er, ez, ev);
        compare(req_of(op), op, a, b, r, er);
        compare("R7", op, a, b, {63'd0, z}, {63'd0, ez});
        compare((op == 2 || op == 6) ? "R3" : "R4", op, a, b, {63'd0, v}, {63'd0, ev});
    endtask

    task automatic step_wide(input int op, input logic [WIDE-1:0] a, input logic [WIDE-1:0] b);
        @(posedge clk);
        op_w = 4'(op); a_w = a; b_w = b;
        @(negedge clk);
        check_all(WIDE, op, a, b, r_w, z_w, v_w);
    endtask

    task automatic step_narrow(input int op, input int a, input int b);
        @(posedge clk);
        op_n = 4'(op); a_n = NARROW'(a); b_n = NARROW'(b);
        @(negedge clk);
        check_all(NARROW, op, a, b, r_n, z_n, v_n);
    endtask

    logic [WIDE-1:0] edges [10] = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                    32'h7FFF_FFFE, 32'h8000_0000, 32'h8000_0001,
                                    32'h5555_5555, 32'hAAAA_AAAA};

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        op_w = 4'd0; a_w = '0; b_w = '0;
        op_n = 4'd0; a_n = '0; b_n = '0;
        // Idle state: AND of zeros gives zero result, zero flag set (R7)
        @(negedge clk);
        compare("R7", 0, 0, 0, {63'd0, z_w}, 64'd1);
        compare("R4", 0, 0, 0, {63'd0, v_w}, 64'd0);

        // Signed extremes and patterns, every code (R1..R8)
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    step_wide(op, edges[i], edges[j]);

        // Random words, every code
        for (int k = 0; k < 200; k++) begin
            logic [WIDE-1:0] ra = $urandom;
            logic [WIDE-1:0] rb = (k % 4 == 0) ? ra : $urandom;
            for (int op = 0; op < 16; op++)
                step_wide(op, ra, rb);
        end

        // Exhaustive at 4 bits: every pair, every code
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    step_narrow(op, a, b);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule